// File: doc/BRIEF.md
# UART Interrupt Register Bank

This block holds the interrupt bookkeeping of a serial port: a latched state register with one bit per event source, a matching enable register, a test register that forces bits into the state register, and a one-shot alert test strobe. The serial engine elsewhere on the chip raises one-cycle pulses on the event inputs. Software sees the bank through a simple 32-bit register bus with word-aligned offsets, and the interrupt controller sees one registered level output per source.

The nine sources sit at fixed bit positions, from bit 0 upward: transmit watermark, receive watermark, transmit done, receive overflow, receive framing error, receive break, receive timeout, receive parity error and transmit empty. A state bit stays set until software writes a one to it. Its output is raised while the matching enable bit is also set.

Top module: `uart_irq_regs`

## Requirements
- R1: A synchronous active-high reset clears the state register, the enable register, every interrupt output and the alert strobe.
- R2: An event pulse on source i sets state bit i, which reads back at word offset 0x00. The bit map from bit 0 is: tx watermark, rx watermark, tx done, rx overflow, rx frame error, rx break, rx timeout, rx parity error, tx empty (bit 8).
- R3: A write to offset 0x00 clears each state bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: A write to offset 0x08 ORs write-data bits 8..0 into the state register.
- R5: A write to offset 0x04 loads write-data bits 8..0 into the enable register, which reads back at offset 0x04.
- R6: Interrupt output i equals state bit i AND enable bit i, taken from the register values one clock earlier.
- R7: If an event pulse and a write-one-clear hit the same state bit in the same cycle, the bit is set afterwards.
- R8: Read-data bits 31..9 are always zero, and write-data bits 31..9 have no effect on any register.
- R9: Reads of offset 0x08, offset 0x0C and any unmapped word return zero. Read data is combinational on the current address and register contents.
- R10: A write to offset 0x0C with write-data bit 0 set raises the alert test output for exactly the following cycle. The same write with bit 0 clear raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte address; bits 1..0 are ignored |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_pulse | input | 9 | One-cycle event pulses, one per source |
| irq_out | output | 9 | Registered interrupt levels |
| alert_fatal_test | output | 1 | One-cycle fatal alert test strobe |

## Verification
The bench builds the block with its default parameters: nine sources, a 6-bit address and 32-bit data. This brings all sixteen word offsets of the window within reach, so reads of the unused words can be checked, and a full 32-bit write can be shown to leave bits above the ninth unchanged. Directed phases cover each source pulse, the clear, set and enable writes, and the case where a pulse collides with a clear. Random traffic then covers overlapping events, writes and alerts across the whole window.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned IRQ_SRC_COUNT = 9;

  // Word indices (byte offset / 4) of the mapped registers.
  localparam int unsigned WORD_STATE  = 0;
  localparam int unsigned WORD_ENABLE = 1;
  localparam int unsigned WORD_TEST   = 2;
  localparam int unsigned WORD_ALERT  = 3;

  typedef enum int unsigned {
    SRC_TX_WMARK   = 0,
    SRC_RX_WMARK   = 1,
    SRC_TX_DONE    = 2,
    SRC_RX_OVF     = 3,
    SRC_RX_FRAME   = 4,
    SRC_RX_BREAK   = 5,
    SRC_RX_TIMEOUT = 6,
    SRC_RX_PARITY  = 7,
    SRC_TX_EMPTY   = 8
  } irq_src_e;

  typedef enum logic [1:0] {
    RD_STATE  = 2'd0,
    RD_ENABLE = 2'd1,
    RD_ZERO   = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic state_clr;
    logic enable_ld;
    logic test_set;
    logic alert;
  } wr_strobe_t;

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_strobe_t        wr,
  output rd_sel_e           rd_sel
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_byte_lane;

  assign word             = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];

  always_comb begin
    wr.state_clr = we && (word == WORD_W'(WORD_STATE));
    wr.enable_ld = we && (word == WORD_W'(WORD_ENABLE));
    wr.test_set  = we && (word == WORD_W'(WORD_TEST));
    wr.alert     = we && (word == WORD_W'(WORD_ALERT));
  end

  always_comb begin
    if (word == WORD_W'(WORD_STATE))       rd_sel = RD_STATE;
    else if (word == WORD_W'(WORD_ENABLE)) rd_sel = RD_ENABLE;
    else                                   rd_sel = RD_ZERO;
  end
endmodule

// File: rtl/uart_irq_state_bank.sv
module uart_irq_state_bank #(
  parameter int unsigned NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_en,
  input  logic               set_en,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] state_q
);
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] set_mask;

  assign clr_mask = clr_en ? wdata : '0;
  assign set_mask = set_en ? wdata : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // Event and test set take priority over a same-cycle clear.
    always_ff @(posedge clk) begin
      if (rst) state_q[i] <= 1'b0;
      else     state_q[i] <= evt[i] | set_mask[i] | (state_q[i] & ~clr_mask[i]);
    end
  end
endmodule

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
  parameter int unsigned NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (load) en_q <= wdata;
  end
endmodule

// File: rtl/uart_irq_out_stage.sv
module uart_irq_out_stage #(
  parameter int unsigned NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] state_q,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic               alert_req,
  output logic [NUM_SRC-1:0] irq_q,
  output logic               alert_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      alert_q <= 1'b0;
    end else begin
      irq_q   <= state_q & en_q;
      alert_q <= alert_req;
    end
  end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQ_SRC_COUNT,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic [NUM_SRC-1:0] irq_out,
  output logic               alert_fatal_test
);
  localparam int unsigned SPARE_W = DATA_W - NUM_SRC;

  wr_strobe_t         wr;
  rd_sel_e            rd_sel;
  logic [NUM_SRC-1:0] wfield;
  logic [SPARE_W-1:0] unused_wdata_hi;
  logic [NUM_SRC-1:0] state_q;
  logic [NUM_SRC-1:0] en_q;

  assign wfield          = reg_wdata[NUM_SRC-1:0];
  assign unused_wdata_hi = reg_wdata[DATA_W-1:NUM_SRC];

  uart_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (reg_addr),
    .we     (reg_we),
    .wr     (wr),
    .rd_sel (rd_sel)
  );

  uart_irq_state_bank #(.NUM_SRC(NUM_SRC)) u_state (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_pulse),
    .clr_en  (wr.state_clr),
    .set_en  (wr.test_set),
    .wdata   (wfield),
    .state_q (state_q)
  );

  uart_irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk   (clk),
    .rst   (rst),
    .load  (wr.enable_ld),
    .wdata (wfield),
    .en_q  (en_q)
  );

  uart_irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .en_q      (en_q),
    .alert_req (wr.alert && reg_wdata[0]),
    .irq_q     (irq_out),
    .alert_q   (alert_fatal_test)
  );

  always_comb begin
    reg_rdata = '0;
    case (rd_sel)
      RD_STATE:  reg_rdata[NUM_SRC-1:0] = state_q;
      RD_ENABLE: reg_rdata[NUM_SRC-1:0] = en_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_regs_chk.sv
module uart_irq_regs_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQ_SRC_COUNT,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_we,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic [NUM_SRC-1:0] irq_out,
  input logic               alert_fatal_test,
  input logic [NUM_SRC-1:0] state_q,
  input logic [NUM_SRC-1:0] en_q
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic               w_state, w_test, w_alert;
  logic [NUM_SRC-1:0] wf;

  assign w_state = reg_we && (reg_addr[ADDR_W-1:2] == WORD_W'(WORD_STATE));
  assign w_test  = reg_we && (reg_addr[ADDR_W-1:2] == WORD_W'(WORD_TEST));
  assign w_alert = reg_we && (reg_addr[ADDR_W-1:2] == WORD_W'(WORD_ALERT));
  assign wf      = reg_wdata[NUM_SRC-1:0];

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (state_q == '0 && en_q == '0 && irq_out == '0 && !alert_fatal_test));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (w_state && evt_pulse == '0) |=> ((state_q & $past(wf)) == '0));

  assert_test_sets_R4: assert property (@(posedge clk) disable iff (rst)
    w_test |=> ((state_q & $past(wf)) == $past(wf)));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~$past(en_q)) == '0));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |=> ((state_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[DATA_W-1:NUM_SRC] == '0));

  assert_alert_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_fatal_test) |-> $past(w_alert && reg_wdata[0]));
endmodule

bind uart_irq_regs uart_irq_regs_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .reg_addr         (reg_addr),
  .reg_we           (reg_we),
  .reg_wdata        (reg_wdata),
  .reg_rdata        (reg_rdata),
  .evt_pulse        (evt_pulse),
  .irq_out          (irq_out),
  .alert_fatal_test (alert_fatal_test),
  .state_q          (state_q),
  .en_q             (en_q)
);

// File: tb/uart_irq_regs_test.sv
module uart_irq_regs_test;
  localparam int NSRC = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  evt_pulse = '0;
  logic [8:0]  irq_out;
  logic        alert_fatal_test;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [8:0] m_state = '0, m_en = '0, m_irq = '0;
  logic       m_alert = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_regs uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq_out(irq_out), .alert_fatal_test(alert_fatal_test)
  );

  function automatic logic [31:0] model_read(input logic [5:0] a);
    case (a[5:2])
      4'd0:    return {23'd0, m_state};
      4'd1:    return {23'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge();
    int w;
    logic [8:0] clr, setm;
    w = int'(reg_addr[5:2]);
    if (rst) begin
      m_state = '0; m_en = '0; m_irq = '0; m_alert = 1'b0;
    end else begin
      m_irq   = m_state & m_en;
      m_alert = reg_we && w == 3 && reg_wdata[0];
      clr  = (reg_we && w == 0) ? reg_wdata[8:0] : 9'd0;
      setm = (reg_we && w == 2) ? reg_wdata[8:0] : 9'd0;
      m_state = (m_state & ~clr) | setm | evt_pulse;
      if (reg_we && w == 1) m_en = reg_wdata[8:0];
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (irq_out !== m_irq) begin
      errors++;
      $display("FAIL R6 (%s) irq_out actual %h expected %h", tag, irq_out, m_irq);
    end
    checks++;
    if (alert_fatal_test !== m_alert) begin
      errors++;
      $display("FAIL R10 (%s) alert actual %b expected %b", tag, alert_fatal_test, m_alert);
    end
    checks++;
    if (reg_rdata !== model_read(reg_addr)) begin
      errors++;
      $display("FAIL %s rdata @%h actual %h expected %h", tag, reg_addr, reg_rdata,
               model_read(reg_addr));
    end
  endtask

  // Called at a negative edge: drive, let one rising edge pass, compare.
  task automatic cyc(input logic [5:0] a, input logic we, input logic [31:0] wd,
                     input logic [8:0] ev, input string tag);
    reg_addr = a; reg_we = we; reg_wdata = wd; evt_pulse = ev;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc(6'h00, 0, 0, 0, "R1");
    cyc(6'h04, 0, 0, 0, "R1");
    rst = 1'b0;
    cyc(6'h00, 0, 0, 0, "R1");

    // R2: each source alone, in bit order
    for (int i = 0; i < NSRC; i++) cyc(6'h00, 0, 0, 9'(1 << i), "R2");
    cyc(6'h00, 1, 32'h1FF, 0, "R3");

    // R5 and R8: enable load, upper bits dropped
    cyc(6'h04, 1, 32'hFFFF_FE5A, 0, "R5");
    cyc(6'h04, 1, 32'hFFFF_FFFF, 0, "R8");
    cyc(6'h07, 0, 0, 0, "R8");

    // R4 then R3: set through test word, partial clear
    cyc(6'h08, 1, 32'hFFFF_FEF3, 0, "R4");
    cyc(6'h00, 0, 0, 0, "R4");
    cyc(6'h00, 1, 32'h0000_0055, 0, "R3");
    cyc(6'h00, 0, 0, 0, "R6");
    cyc(6'h00, 1, 32'hFFFF_FE00, 0, "R8");

    // R7: event collides with clear of the same bit
    cyc(6'h00, 1, 32'h1FF, 9'h104, "R7");
    cyc(6'h00, 0, 0, 0, "R7");

    // R9: test, alert and unmapped words read zero
    cyc(6'h08, 0, 0, 0, "R9");
    cyc(6'h0C, 0, 0, 0, "R9");
    cyc(6'h10, 0, 0, 0, "R9");
    cyc(6'h3C, 0, 0, 0, "R9");

    // R10: alert strobe with bit 0 set, then clear, then back-to-back
    cyc(6'h0C, 1, 32'h1, 0, "R10");
    cyc(6'h00, 0, 0, 0, "R10");
    cyc(6'h0C, 1, 32'hFFFF_FFFE, 0, "R10");
    cyc(6'h00, 0, 0, 0, "R10");
    cyc(6'h0C, 1, 32'h1, 0, "R10");
    cyc(6'h0C, 1, 32'h1, 0, "R10");
    cyc(6'h00, 0, 0, 0, "R10");

    // Random traffic across the window
    for (int n = 0; n < 400; n++) begin
      cyc(6'($urandom), ($urandom % 3) == 0, $urandom,
          (($urandom % 2) == 0) ? 9'($urandom) : 9'd0, "R6");
    end

    // R1: reset mid-run after filling state and enable
    cyc(6'h04, 1, 32'h1FF, 9'h1FF, "R1");
    cyc(6'h00, 0, 0, 0, "R1");
    rst = 1'b1;
    cyc(6'h00, 0, 0, 9'h0FF, "R1");
    rst = 1'b0;
    cyc(6'h04, 0, 0, 0, "R1");
    cyc(6'h00, 0, 0, 0, "R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule